// File: doc/BRIEF.md
# Fast-to-Slow Bus Access Synchronizer

This block sits between a CPU running on an accelerated clock and a system bus that keeps the original slow timing. Most CPU accesses finish at the fast rate. These are accesses outside the slow address windows, and reads that hit in the CPU cache. When an access decodes to a slow window and cannot be served from the cache, the block stalls the CPU and waits for the next slow-cycle start strobe. It then drives the captured access onto the slow bus for exactly one slow cycle, and releases the CPU when that cycle ends. Writes to the slow region always take this path, so they are never posted.

The slow-cycle start strobe comes from the same clock tree as the fast clock. It is a one-fast-cycle pulse that marks where each slow cycle begins. The spacing between strobes may vary, for example when the slow side stretches a cycle. The block never issues a slow request anywhere except just after a strobe, so the slow side's own timing is left undisturbed. Data read over the slow bus is captured when the slow cycle ends. It stays on the CPU read-data output until the next slow read completes.

Top module: `accel_bus_sync`

## Requirements
- R1: While reset is high, `slow_req` is 0 and `cpu_rdata` is 0. After reset with no valid access, `cpu_ready` is 1.
- R2: A valid access whose address is outside both slow windows completes in its first cycle (`cpu_ready` 1) and raises no `slow_req`. The default slow windows are 0x0400 to 0x0BFF and 0xC000 to 0xCFFF, inclusive.
- R3: A read inside a slow window with `cpu_cache_hit` 1 completes in its first cycle without raising `slow_req`.
- R4: A write inside a slow window takes the slow path even when `cpu_cache_hit` is 1. `cpu_ready` stays 0 for as long as `slow_req` is 1.
- R5: A slow-path access first presented in cycle t raises `slow_req` in the cycle after the first strobe at or after cycle t.
- R6: `slow_req` stays 1 for exactly one slow cycle. It falls in the cycle after the next strobe.
- R7: `cpu_ready` returns to 1 in the cycle just after `slow_req` falls.
- R8: While `slow_req` is 1, `slow_addr`, `slow_we` and `slow_wdata` hold the access that was captured, and they do not change.
- R9: `cpu_rdata` takes the `slow_rdata` value present in the strobe cycle that ends a slow read. It keeps that value through later fast accesses and slow writes.
- R10: `slow_req` never rises except in the cycle that follows a slow-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_start | input | 1 | One-cycle strobe marking the start of each slow cycle |
| cpu_valid | input | 1 | CPU access present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW (16) | CPU address |
| cpu_wdata | input | DW (8) | CPU write data |
| cpu_cache_hit | input | 1 | Read data available from the CPU cache |
| cpu_ready | output | 1 | Access completes this cycle; 0 = stall |
| cpu_rdata | output | DW (8) | Data from the last completed slow read |
| slow_req | output | 1 | Slow bus access in progress |
| slow_we | output | 1 | Direction of the slow bus access |
| slow_addr | output | AW (16) | Address of the slow bus access |
| slow_wdata | output | DW (8) | Write data of the slow bus access |
| slow_rdata | input | DW (8) | Read data returned by the slow bus |

## Verification
A sequencer stuck in its wait or bus state shows up as `cpu_ready` held at 0. A wrong state choice on entry shows up as a request rising one strobe early or late. Both are caught within one slow period, because the bench compares every completion cycle with the strobe schedule it generates. A capture register loaded at the wrong moment shows up as a changing slow address or data in the middle of a request. A read latched on the wrong edge shows up in `cpu_rdata` in the first cycle after the access completes. A wrongly decoded window or cache-hit path turns a one-cycle access into a stall on the first access of that kind.

// File: rtl/accel_bus_sync_pkg.sv
package accel_bus_sync_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_BUS  = 2'd2,
        SQ_DONE = 2'd3
    } seq_state_t;

    function automatic logic addr_in_range(
        input logic [31:0] addr,
        input logic [31:0] lo,
        input logic [31:0] hi
    );
        return (addr >= lo) && (addr <= hi);
    endfunction

endpackage

// File: rtl/abs_region_decode.sv
module abs_region_decode #(
    parameter int AW   = 16,
    parameter int NWIN = 2,
    parameter logic [NWIN-1:0][AW-1:0] WIN_LO = '0,
    parameter logic [NWIN-1:0][AW-1:0] WIN_HI = '0
) (
    input  logic [AW-1:0] addr,
    output logic          in_slow
);
    import accel_bus_sync_pkg::*;

    logic [NWIN-1:0] hit_vec;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        assign hit_vec[w] = addr_in_range(32'(addr), 32'(WIN_LO[w]), 32'(WIN_HI[w]));
    end

    assign in_slow = |hit_vec;
endmodule

// File: rtl/abs_sequencer.sv
module abs_sequencer (
    input  logic clk,
    input  logic rst,
    input  logic need_slow,
    input  logic slow_start,
    output logic accept,
    output logic end_cycle,
    output logic req,
    output logic ready
);
    import accel_bus_sync_pkg::*;

    seq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: if (need_slow) state_d = slow_start ? SQ_BUS : SQ_WAIT;
            SQ_WAIT: if (slow_start) state_d = SQ_BUS;
            SQ_BUS:  if (slow_start) state_d = SQ_DONE;
            SQ_DONE: state_d = SQ_IDLE;
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SQ_IDLE;
        else     state_q <= state_d;
    end

    assign accept    = (state_q == SQ_IDLE) && need_slow;
    assign end_cycle = (state_q == SQ_BUS) && slow_start;
    assign req       = (state_q == SQ_BUS);
    assign ready     = ((state_q == SQ_IDLE) && !need_slow) || (state_q == SQ_DONE);
endmodule

// File: rtl/abs_capture.sv
module abs_capture #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          end_cycle,
    input  logic          in_we,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          hold_we,
    output logic [AW-1:0] hold_addr,
    output logic [DW-1:0] hold_wdata,
    output logic [DW-1:0] hold_rdata
);
    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } access_t;

    access_t       acc_q;
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            rd_q  <= '0;
        end else begin
            if (accept) acc_q <= '{we: in_we, addr: in_addr, wdata: in_wdata};
            if (end_cycle && !acc_q.we) rd_q <= bus_rdata;
        end
    end

    assign hold_we    = acc_q.we;
    assign hold_addr  = acc_q.addr;
    assign hold_wdata = acc_q.wdata;
    assign hold_rdata = rd_q;
endmodule

// File: rtl/accel_bus_sync.sv
module accel_bus_sync #(
    parameter int AW   = 16,
    parameter int DW   = 8,
    parameter int NWIN = 2,
    parameter logic [NWIN-1:0][AW-1:0] WIN_LO = {16'hC000, 16'h0400},
    parameter logic [NWIN-1:0][AW-1:0] WIN_HI = {16'hCFFF, 16'h0BFF}
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slow_start,
    input  logic          cpu_valid,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_cache_hit,
    output logic          cpu_ready,
    output logic [DW-1:0] cpu_rdata,
    output logic          slow_req,
    output logic          slow_we,
    output logic [AW-1:0] slow_addr,
    output logic [DW-1:0] slow_wdata,
    input  logic [DW-1:0] slow_rdata
);
    logic in_slow, need_slow, accept, end_cycle;

    abs_region_decode #(.AW(AW), .NWIN(NWIN), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_decode (
        .addr    (cpu_addr),
        .in_slow (in_slow)
    );

    // Writes in a slow window always go to the bus; reads only on a cache miss.
    assign need_slow = cpu_valid && in_slow && (cpu_we || !cpu_cache_hit);

    abs_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .need_slow  (need_slow),
        .slow_start (slow_start),
        .accept     (accept),
        .end_cycle  (end_cycle),
        .req        (slow_req),
        .ready      (cpu_ready)
    );

    abs_capture #(.AW(AW), .DW(DW)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .end_cycle  (end_cycle),
        .in_we      (cpu_we),
        .in_addr    (cpu_addr),
        .in_wdata   (cpu_wdata),
        .bus_rdata  (slow_rdata),
        .hold_we    (slow_we),
        .hold_addr  (slow_addr),
        .hold_wdata (slow_wdata),
        .hold_rdata (cpu_rdata)
    );
endmodule

// File: rtl/accel_bus_sync_chk.sv
module accel_bus_sync_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          slow_start,
    input logic          cpu_ready,
    input logic [DW-1:0] cpu_rdata,
    input logic          slow_req,
    input logic          slow_we,
    input logic [AW-1:0] slow_addr,
    input logic [DW-1:0] slow_wdata
);
    assert_req_on_boundary_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(slow_req) |-> $past(slow_start));

    assert_req_one_slow_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        (slow_req && slow_start) |=> !slow_req);

    assert_no_posted_write_R4: assert property (@(posedge clk) disable iff (rst)
        slow_req |-> !cpu_ready);

    assert_release_after_bus_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(slow_req) |-> cpu_ready);

    assert_bus_fields_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (slow_req && $past(slow_req)) |-> ($stable(slow_addr) && $stable(slow_we) && $stable(slow_wdata)));

    assert_rdata_only_on_read_end_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(cpu_rdata) |-> ($fell(slow_req) && !slow_we));
endmodule

bind accel_bus_sync accel_bus_sync_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .slow_start (slow_start),
    .cpu_ready  (cpu_ready),
    .cpu_rdata  (cpu_rdata),
    .slow_req   (slow_req),
    .slow_we    (slow_we),
    .slow_addr  (slow_addr),
    .slow_wdata (slow_wdata)
);

// File: tb/accel_bus_sync_bench.sv
module accel_bus_sync_bench;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          slow_start;
    logic          cpu_valid = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_cache_hit = 1'b0;
    logic          cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic          slow_req;
    logic          slow_we;
    logic [AW-1:0] slow_addr;
    logic [DW-1:0] slow_wdata;
    logic [DW-1:0] slow_rdata;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int last_rise = -1;
    logic          prev_req = 1'b0;
    logic          mon_on = 1'b0;
    logic          exp_we = 1'b0;
    logic [AW-1:0] exp_addr = '0;
    logic [DW-1:0] exp_wdata = '0;
    logic [DW-1:0] last_rd = '0;

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Slow cycles of 5 and 6 fast cycles alternate (a stretched slow cycle).
    function automatic bit is_strobe(input int c);
        return (c % 11 == 0) || (c % 11 == 5);
    endfunction

    function automatic int next_strobe(input int c);
        int s = c;
        while (!is_strobe(s)) s++;
        return s;
    endfunction

    function automatic logic [DW-1:0] bus_data(input int c);
        return DW'(c) ^ 8'h5A;
    endfunction

    function automatic bit exp_slow(input logic [AW-1:0] a, input logic we, input logic hit);
        bit inwin = (a >= 16'h0400 && a <= 16'h0BFF) || (a >= 16'hC000 && a <= 16'hCFFF);
        return inwin && (we || !hit);
    endfunction

    assign slow_start = is_strobe(cyc);
    assign slow_rdata = bus_data(cyc);

    accel_bus_sync u_accel_bus_sync (
        .clk           (clk),
        .rst           (rst),
        .slow_start    (slow_start),
        .cpu_valid     (cpu_valid),
        .cpu_we        (cpu_we),
        .cpu_addr      (cpu_addr),
        .cpu_wdata     (cpu_wdata),
        .cpu_cache_hit (cpu_cache_hit),
        .cpu_ready     (cpu_ready),
        .cpu_rdata     (cpu_rdata),
        .slow_req      (slow_req),
        .slow_we       (slow_we),
        .slow_addr     (slow_addr),
        .slow_wdata    (slow_wdata),
        .slow_rdata    (slow_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: request edges against the strobe schedule, bus fields during a request.
    always begin
        @(negedge clk);
        #1;
        if (!rst && mon_on) begin
            if (slow_req && !prev_req) begin
                last_rise = cyc;
                check(is_strobe(cyc - 1), "R10 rise after strobe", cyc, next_strobe(cyc));
            end
            if (!slow_req && prev_req)
                check(is_strobe(cyc - 1), "R6 fall after strobe", cyc, next_strobe(cyc - 1) + 1);
            if (slow_req) begin
                check(slow_addr == exp_addr, "R8 slow_addr", int'(slow_addr), int'(exp_addr));
                check(slow_we == exp_we, "R8 slow_we", int'(slow_we), int'(exp_we));
                if (exp_we)
                    check(slow_wdata == exp_wdata, "R8 slow_wdata", int'(slow_wdata), int'(exp_wdata));
                check(!cpu_ready, "R4 stall during request", int'(cpu_ready), 0);
            end
        end
        prev_req = slow_req;
    end

    task automatic access(input logic [AW-1:0] a, input logic we, input logic hit,
                          input logic [DW-1:0] wd, input int phase);
        int t;
        int s1;
        int s2;
        int guard;
        @(negedge clk);
        cpu_valid = 1'b0;
        while (phase >= 0 && (cyc % 11) != phase) @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_cache_hit = hit;
        t = cyc;
        #1;
        if (!exp_slow(a, we, hit)) begin
            check(cpu_ready == 1'b1, hit ? "R3 hit completes at once" : "R2 fast completes at once",
                  int'(cpu_ready), 1);
            check(slow_req == 1'b0, "R2/R3 no request", int'(slow_req), 0);
            check(cpu_rdata == last_rd, "R9 rdata held over fast access", int'(cpu_rdata), int'(last_rd));
        end else begin
            exp_we = we; exp_addr = a; exp_wdata = wd;
            s1 = next_strobe(t);
            s2 = next_strobe(s1 + 1);
            guard = 0;
            while (!cpu_ready && guard < 40) begin
                @(negedge clk);
                #1;
                guard++;
            end
            check(cyc == s2 + 1, "R7 completion cycle", cyc - t, s2 + 1 - t);
            check(last_rise == s1 + 1, "R5 request start", last_rise, s1 + 1);
            if (we) begin
                check(cpu_rdata == last_rd, "R9 rdata held over slow write", int'(cpu_rdata), int'(last_rd));
            end else begin
                check(cpu_rdata == bus_data(s2), "R9 rdata captured", int'(cpu_rdata), int'(bus_data(s2)));
                last_rd = bus_data(s2);
            end
        end
    endtask

    function automatic logic [AW-1:0] pick_addr(input int kind);
        int r = int'($urandom % 32'h800);
        case (kind)
            0: return AW'(32'h1000 + ($urandom % 32'hB000));
            1: return AW'(32'h0400 + r);
            default: return AW'(32'hC000 + ($urandom % 32'h1000));
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        #1;
        check(slow_req == 1'b0, "R1 req in reset", int'(slow_req), 0);
        check(cpu_rdata == '0, "R1 rdata in reset", int'(cpu_rdata), 0);
        @(negedge clk);
        rst = 1'b0;
        mon_on = 1'b1;
        @(negedge clk);
        #1;
        check(cpu_ready == 1'b1, "R1 ready when idle", int'(cpu_ready), 1);

        // Directed corner cases.
        access(16'h2000, 1'b0, 1'b0, 8'h00, -1);   // R2 fast read
        access(16'hF000, 1'b1, 1'b0, 8'h11, -1);   // R2 fast write
        access(16'h03FF, 1'b1, 1'b0, 8'h12, -1);   // R2 just below window
        access(16'h0C00, 1'b0, 1'b0, 8'h00, -1);   // R2 just above window
        access(16'h0400, 1'b0, 1'b1, 8'h00, -1);   // R3 window edge, cache hit
        access(16'h0400, 1'b0, 1'b0, 8'h00, 0);    // R5 issued on a strobe
        access(16'h0BFF, 1'b0, 1'b0, 8'h00, 1);    // R5 issued just after a strobe
        access(16'hCFFF, 1'b1, 1'b1, 8'hA5, 5);    // R4 write with hit still slow
        access(16'hC000, 1'b1, 1'b0, 8'h3C, 6);    // R4 write, long wait
        access(16'h0800, 1'b0, 1'b1, 8'h00, -1);   // R9 rdata held over hit
        access(16'h0500, 1'b0, 1'b0, 8'h00, 4);    // R5 issued just before strobe

        // Back-to-back slow reads with no idle gap.
        for (int i = 0; i < 3; i++) access(16'h0600 + AW'(i), 1'b0, 1'b0, 8'h00, -1);

        // Constrained random mix.
        for (int i = 0; i < 80; i++) begin
            int kind = int'($urandom % 3);
            logic we = 1'($urandom);
            logic hit = 1'($urandom);
            access(pick_addr(kind), we, hit, 8'($urandom), ($urandom % 4 == 0) ? int'($urandom % 11) : -1);
            if ($urandom % 3 == 0) begin
                @(negedge clk);
                cpu_valid = 1'b0;
                #1;
                check(slow_req == 1'b0, "R2 no request when idle", int'(slow_req), 0);
            end
        end

        @(negedge clk);
        cpu_valid = 1'b0;
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule